// File: doc/BRIEF.md
# Streaming Three-Tap Mean Filter

This block takes unsigned pixels one per handshake on an input stream and emits the integer mean of each pixel and its two neighbours in stream order. A frame is treated as one flat run of pixels, with no row boundaries. The last pixel of a frame is marked by a flag on the input. The block is a two-phase actor. In the fill phase it absorbs the first two pixels of a frame and produces nothing. In the stream phase every accepted pixel yields one mean.

The window is a three-slot store. Each new pixel overwrites the oldest slot, chosen by a rotating write pointer, so stored data never moves. The result is held in an output register and stays there until the consumer takes it. The block can accept a new pixel only when that register is empty or is being drained in the same cycle.

Top module: `avg3_stream`

## Requirements
- R1: While reset is asserted and immediately after it is released, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: The first two pixels accepted in a frame produce no output: `out_valid_o` is 0 in the cycle after each of them is accepted.
- R3: The third and every later accepted pixel of a frame, with value c, produce one output equal to floor((a+b+c)/3), where a and b are the two pixels accepted just before it in the same frame. All values are unsigned 8-bit and the 10-bit sum is divided with truncation.
- R4: An output becomes valid in the cycle right after the accepting clock edge of the pixel that produced it.
- R5: While `out_valid_o` is 1 and `out_ready_i` is 0, `in_ready_o` is 0, and on the next cycle `out_valid_o` stays 1 with `out_data_o` unchanged.
- R6: In a cycle where no pixel is accepted, the data, last flag and valid level on the input change nothing. Once any pending output has been taken, `out_valid_o` returns to 0.
- R7: A pixel accepted with `in_last_i` = 1 ends the frame. A frame of N accepted pixels yields exactly max(N-2, 0) outputs, and the next pixel starts a new frame in the fill phase with no values carried over.
- R8: A frame of exactly three pixels yields a single output. A frame that directly follows it produces results from its own pixels only.
- R9: Extreme and truncating values are exact: three 255s give 255, and the inputs (0,0,2) give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pixel valid |
| in_data_i | input | DATA_W | Input pixel value |
| in_last_i | input | 1 | Marks the final pixel of a frame |
| in_ready_o | output | 1 | Block can accept a pixel this cycle |
| out_valid_o | output | 1 | Output mean valid |
| out_data_o | output | DATA_W | Mean of three consecutive pixels |
| out_ready_i | input | 1 | Consumer accepts the output |

## Verification
The assertions assume the consumer obeys the handshake: a pixel counts as accepted only when `in_valid_i` and `in_ready_o` are both high at a clock edge. They also assume `in_last_i` has meaning only on an accepted pixel. The frame counter in the checker depends on both assumptions. The stimulus holds each pixel and its last flag stable until it is accepted. It puts random data and random last flags on the input during idle gaps to test that they are ignored. It drops `out_ready_i` at random so that stalls also fall on the first and last pixels of a frame.

// File: rtl/avg3_pkg.sv
package avg3_pkg;
  typedef enum logic {PH_FILL = 1'b0, PH_STREAM = 1'b1} phase_e;
  localparam int unsigned TAPS  = 3;
  localparam int unsigned PTR_W = $clog2(TAPS);
endpackage

// File: rtl/avg3_window.sv
module avg3_window
  import avg3_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SUM_W = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [SUM_W-1:0]  sum_o
);
  logic [DATA_W-1:0] slot_q [TAPS];
  logic [DATA_W-1:0] view   [TAPS];
  logic [PTR_W-1:0]  ptr_q;

  // window as it will look once the incoming pixel replaces the slot at ptr_q
  for (genvar j = 0; j < TAPS; j++) begin : g_slot
    assign view[j] = (ptr_q == PTR_W'(j)) ? data_i : slot_q[j];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              slot_q[j] <= '0;
      else if (clear_i)                         slot_q[j] <= '0;
      else if (wr_i && ptr_q == PTR_W'(j))      slot_q[j] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (clear_i) ptr_q <= '0;
    else if (wr_i)    ptr_q <= (ptr_q == PTR_W'(TAPS - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < TAPS; k++) sum_o = sum_o + SUM_W'(view[k]);
  end
endmodule

// File: rtl/avg3_div.sv
module avg3_div #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SUM_W = DATA_W + 2
) (
  input  logic [SUM_W-1:0]  sum_i,
  output logic [DATA_W-1:0] quo_o
);
  logic [SUM_W-1:0] q_full;
  assign q_full = sum_i / SUM_W'(3);
  assign quo_o  = q_full[DATA_W-1:0];
endmodule

// File: rtl/avg3_ctrl.sv
module avg3_ctrl
  import avg3_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic last_i,
  output logic emit_o,
  output logic clear_o
);
  phase_e phase_q;
  logic   fill_q;

  assign emit_o  = fire_i && (phase_q == PH_STREAM);
  assign clear_o = fire_i && last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FILL;
      fill_q  <= 1'b0;
    end else if (fire_i) begin
      if (last_i) begin
        phase_q <= PH_FILL;
        fill_q  <= 1'b0;
      end else if (phase_q == PH_FILL) begin
        if (fill_q) begin
          phase_q <= PH_STREAM;
          fill_q  <= 1'b0;
        end else begin
          fill_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/avg3_stream.sv
module avg3_stream #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SUM_W = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i
);
  logic              fire, emit, clear;
  logic [SUM_W-1:0]  sum;
  logic [DATA_W-1:0] mean;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign fire       = in_valid_i && in_ready_o;

  avg3_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .last_i (in_last_i),
    .emit_o (emit),
    .clear_o(clear)
  );

  avg3_window #(.DATA_W(DATA_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .wr_i   (fire),
    .data_i (in_data_i),
    .sum_o  (sum)
  );

  avg3_div #(.DATA_W(DATA_W)) u_div (
    .sum_i(sum),
    .quo_o(mean)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (emit) begin
      out_valid_o <= 1'b1;
      out_data_o  <= mean;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/avg3_checker.sv
module avg3_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_last_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_ready_i
);
  logic       fire;
  logic       stall;
  logic [1:0] seen_q;

  assign fire  = in_valid_i && in_ready_o;
  assign stall = out_valid_o && !out_ready_i;

  // pixels accepted in the current frame, saturating at 2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      seen_q <= 2'd0;
    else if (fire && in_last_i)       seen_q <= 2'd0;
    else if (fire && seen_q != 2'd2)  seen_q <= seen_q + 2'd1;
  end

  assert_stall_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |-> !in_ready_o);

  assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> out_valid_o && $stable(out_data_o));

  assert_fill_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && seen_q != 2'd2) |=> !out_valid_o);

  assert_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && seen_q == 2'd2) |=> out_valid_o);

  assert_idle_drain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire && !stall) |=> !out_valid_o);
endmodule

bind avg3_stream avg3_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_last_i  (in_last_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o),
  .out_ready_i(out_ready_i)
);

// File: tb/sim_avg3_stream.sv
module sim_avg3_stream;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_last_i = 1'b0;
  logic       in_ready_o;
  logic       out_valid_o;
  logic [7:0] out_data_o;
  logic       out_ready_i = 1'b0;

  always #10 clk = ~clk;

  avg3_stream #(.DATA_W(8)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_last_i  (in_last_i),
    .in_ready_o (in_ready_o),
    .out_valid_o(out_valid_o),
    .out_data_o (out_data_o),
    .out_ready_i(out_ready_i)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  int    seen = 0;
  int    p_old = 0;
  int    p_mid = 0;
  bit    pend_fire = 0;
  bit    pend_emit = 0;
  bit    pend_stall = 0;
  int    pend_exp = 0;
  int    stall_data = 0;
  int    emitted = 0;
  string val_tag = "R3";
  int    pix [0:599];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int mean3(input int a, input int b, input int c);
    return (a + b + c) / 3;
  endfunction

  // check what the previous cycle's edge must have produced
  task automatic eval_prev();
    if (pend_fire) begin
      if (pend_emit) begin
        chk(out_valid_o === 1'b1, "R4", int'(out_valid_o), 1);
        chk(int'(out_data_o) == pend_exp, val_tag, int'(out_data_o), pend_exp);
        emitted++;
      end else begin
        chk(out_valid_o === 1'b0, "R2", int'(out_valid_o), 0);
      end
    end else if (pend_stall) begin
      chk(out_valid_o === 1'b1 && int'(out_data_o) == stall_data, "R5",
          int'(out_data_o), stall_data);
    end else begin
      chk(out_valid_o === 1'b0, "R6", int'(out_valid_o), 0);
    end
  endtask

  task automatic cycle(input bit v, input logic [7:0] d, input bit l, input bit r,
                       output bit fired);
    @(negedge clk);
    eval_prev();
    in_valid_i  = v;
    in_data_i   = d;
    in_last_i   = l;
    out_ready_i = r;
    #1;
    fired      = v && in_ready_o;
    pend_stall = out_valid_o && !r;
    if (pend_stall) begin
      chk(in_ready_o === 1'b0, "R5", int'(in_ready_o), 0);
      stall_data = int'(out_data_o);
    end
    pend_fire = fired;
    pend_emit = 1'b0;
    if (fired) begin
      if (seen >= 2) begin
        pend_emit = 1'b1;
        pend_exp  = mean3(p_old, p_mid, int'(d));
      end
      p_old = p_mid;
      p_mid = int'(d);
      seen++;
      if (l) begin
        seen  = 0;
        p_old = 0;
        p_mid = 0;
      end
    end
  endtask

  task automatic send_pixel(input int d, input bit l, input int rdy_pct, input int gap_pct);
    bit fired;
    fired = 1'b0;
    while (!fired) begin
      if (int'($urandom % 100) < gap_pct)
        cycle(1'b0, 8'($urandom), 1'($urandom), int'($urandom % 100) < rdy_pct, fired);
      else
        cycle(1'b1, 8'(d), l, int'($urandom % 100) < rdy_pct, fired);
    end
  endtask

  task automatic send_frame(input int n, input int rdy_pct, input int gap_pct);
    bit dummy;
    int want;
    emitted = 0;
    for (int i = 0; i < n; i++) send_pixel(pix[i], i == n - 1, rdy_pct, gap_pct);
    cycle(1'b0, 8'h00, 1'b0, 1'b1, dummy);
    want = (n > 2) ? n - 2 : 0;
    chk(emitted == want, "R7", emitted, want);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk(out_valid_o === 1'b0 && in_ready_o === 1'b1, "R1", int'(out_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(out_valid_o === 1'b0, "R1", int'(out_valid_o), 0);
    chk(in_ready_o === 1'b1, "R1", int'(in_ready_o), 1);

    // R9 corner values
    val_tag = "R9";
    pix[0] = 1; pix[1] = 1; pix[2] = 2;
    send_frame(3, 100, 0);
    pix[0] = 0; pix[1] = 0; pix[2] = 2;
    send_frame(3, 100, 0);
    for (int i = 0; i < 5; i++) pix[i] = 255;
    send_frame(5, 60, 20);

    // R8 short frames back to back
    val_tag = "R8";
    pix[0] = 9; pix[1] = 30; pix[2] = 60;
    send_frame(3, 100, 0);
    pix[0] = 200; pix[1] = 100; pix[2] = 0;
    send_frame(3, 100, 0);

    // R7 frame shorter than the window
    val_tag = "R7";
    pix[0] = 77; pix[1] = 88;
    send_frame(2, 100, 0);
    pix[0] = 5;
    send_frame(1, 100, 0);

    // R3 ramp under heavy backpressure
    val_tag = "R3";
    for (int i = 0; i < 12; i++) pix[i] = i * 20;
    send_frame(12, 40, 10);

    // R3 random frames
    for (int f = 0; f < 60; f++) begin
      int n;
      n = 3 + int'($urandom % 22);
      for (int i = 0; i < n; i++) pix[i] = int'($urandom % 256);
      send_frame(n, 50 + int'($urandom % 51), int'($urandom % 31));
    end

    // full frame row
    for (int i = 0; i < 512; i++) pix[i] = int'($urandom % 256);
    send_frame(512, 90, 5);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (R6): actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule